// File: doc/BRIEF.md
# USB Device Clock Gating Controller

This block decides which clocks of a USB device controller run. It watches bus activity strokes and a 1 ms timebase tick. After a set number of idle ticks it declares suspend and drops the enable of the 48 MHz protocol clock. Software can keep that clock running through a request bit. It then polls a status bit that rises once the clock is running.

DMA access strobes switch on the bus-master clock. That clock stays on through a retriggerable hold window that is also measured in ticks. A software force bit can keep it on for good. The bus-slave clock runs whenever the peripheral power enable is high. When that enable is low, every enable is gated off.

Each status bit follows its enable through a fixed two-cycle delay, which models clock start-up. A need-clock output summarises the status bits for chip power-down handling.

The protocol-side FSM has two states, `SS_RUN` and `SS_SUSP`:
- `SS_RUN`→`SS_SUSP` on the final idle tick.
- `SS_SUSP`→`SS_RUN` on any activity strobe.

The master-clock FSM has two states, `HS_OFF` and `HS_HOLD`:
- `HS_OFF`→`HS_HOLD` on a DMA strobe.
- `HS_HOLD`→`HS_OFF` on the final hold tick with no strobe.
- A strobe in `HS_HOLD` restarts the window.

Top module: `usb_clkgate_ctrl`

## Requirements
- R1: With no bus activity, `suspended` rises in the cycle after the IDLE_TICKS-th tick (default 3) counted from reset or from the last activity. `dev_clk_en` then falls unless the software request is set.
- R2: A `bus_act` strobe clears the idle count, and in suspend it clears `suspended` in the next cycle. When `bus_act` and `tick_1ms` arrive in the same cycle, the activity wins and the tick is not counted.
- R3: A write with `ctl_wdata` bit 0 set keeps `dev_clk_en` high in suspend, from the cycle after the write until a write clears that bit.
- R4: `stat_rdata` bit 0 equals `dev_clk_en` two cycles earlier, and bit 1 equals `mst_clk_en` two cycles earlier.
- R5: A `dma_acc` strobe sets `mst_clk_en` from the next cycle. The enable falls in the cycle after the HOLD_TICKS-th tick (default 2) with no further access. A new access, including one in the same cycle as a tick, restarts the count.
- R6: A write with `ctl_wdata` bit 1 set keeps `mst_clk_en` high from the next cycle, regardless of DMA activity, until a write clears that bit.
- R7: `slv_clk_en` equals `pwr_en`. While `pwr_en` is low, `dev_clk_en` and `mst_clk_en` are low in the same cycle.
- R8: `need_clk` is high exactly when any bit of `stat_rdata` is high.
- R9: During and after reset, with no stimulus yet applied, the control bits are 0, `suspended` is 0, `stat_rdata` is 0 and the counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Peripheral power enable |
| tick_1ms | input | 1 | Single-cycle 1 ms timebase pulse |
| bus_act | input | 1 | Bus activity strobe |
| dma_acc | input | 1 | DMA access strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 protocol clock request, bit 1 master clock force |
| stat_rdata | output | 2 | Bit 0 protocol clock on, bit 1 master clock on |
| dev_clk_en | output | 1 | Protocol clock enable |
| mst_clk_en | output | 1 | Bus-master clock enable |
| slv_clk_en | output | 1 | Bus-slave clock enable |
| suspended | output | 1 | Suspend state indicator |
| need_clk | output | 1 | Need-clock / wake request |

## Verification
The bench checks ticks that coincide with activity or DMA strobes. A design that counts the tick there would suspend one tick early or drop the master clock too soon. It checks retriggering of the hold window in its last tick, where a non-restarting counter turns the master clock off while DMA is still busy. It checks clearing the software request while suspended, where a latched override would keep the protocol clock running. It also checks dropping `pwr_en` mid-hold: a design that gates only the status bits, and not the enables, would leave the enables high.

// File: rtl/usbcg_pkg.sv
package usbcg_pkg;
    typedef enum logic {
        SS_RUN  = 1'b0,
        SS_SUSP = 1'b1
    } susp_state_t;

    typedef enum logic {
        HS_OFF  = 1'b0,
        HS_HOLD = 1'b1
    } hold_state_t;

    localparam int CTL_DEV_BIT = 0;
    localparam int CTL_MST_BIT = 1;
    localparam int CTL_W       = 2;
    localparam int STAT_W      = 2;
endpackage

// File: rtl/usbcg_idle_fsm.sv
module usbcg_idle_fsm
    import usbcg_pkg::*;
#(
    parameter int IDLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic act,
    output logic susp
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

    susp_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SS_RUN: begin
                if (act) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = SS_SUSP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SS_SUSP: begin
                cnt_d = '0;
                if (act) state_d = SS_RUN;
            end
            default: begin
                state_d = SS_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        susp = (state_q == SS_SUSP);
    end

    p_enter_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp) |-> ($past(tick) && !$past(act)));
    p_wake_on_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && act) |=> !susp);
endmodule

// File: rtl/usbcg_hold_fsm.sv
module usbcg_hold_fsm
    import usbcg_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic acc,
    output logic hold
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    hold_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_OFF: begin
                cnt_d = '0;
                if (acc) state_d = HS_HOLD;
            end
            HS_HOLD: begin
                if (acc) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = HS_OFF;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = HS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        hold = (state_q == HS_HOLD);
    end

    p_acc_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> hold);
    p_drop_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> ($past(tick) && !$past(acc)));
endmodule

// File: rtl/usbcg_stat_pipe.sv
module usbcg_stat_pipe #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/usb_clkgate_ctrl.sv
module usb_clkgate_ctrl
    import usbcg_pkg::*;
#(
    parameter int IDLE_TICKS = 3,
    parameter int HOLD_TICKS = 2,
    parameter int ON_DELAY   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tick_1ms,
    input  logic              bus_act,
    input  logic              dma_acc,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              dev_clk_en,
    output logic              mst_clk_en,
    output logic              slv_clk_en,
    output logic              suspended,
    output logic              need_clk
);
    logic dev_req_q, mst_force_q;
    logic susp_w, hold_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_req_q   <= 1'b0;
            mst_force_q <= 1'b0;
        end else if (ctl_we) begin
            dev_req_q   <= ctl_wdata[CTL_DEV_BIT];
            mst_force_q <= ctl_wdata[CTL_MST_BIT];
        end
    end

    usbcg_idle_fsm #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_1ms),
        .act  (bus_act),
        .susp (susp_w)
    );

    usbcg_hold_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_1ms),
        .acc  (dma_acc),
        .hold (hold_w)
    );

    always_comb begin
        dev_clk_en = pwr_en & (~susp_w | dev_req_q);
        mst_clk_en = pwr_en & (hold_w | mst_force_q);
        slv_clk_en = pwr_en;
        suspended  = susp_w;
    end

    usbcg_stat_pipe #(.W(STAT_W), .DEPTH(ON_DELAY)) u_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mst_clk_en, dev_clk_en}),
        .q    (stat_rdata)
    );

    assign need_clk = |stat_rdata;

    p_req_in_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_w && dev_req_q && pwr_en) |-> dev_clk_en);
    p_force_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_force_q && pwr_en) |-> mst_clk_en);
    p_power_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (!dev_clk_en && !mst_clk_en && !slv_clk_en));
    p_status_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[0] |-> $past(dev_clk_en, 2));
    p_need_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && $past(!pwr_en) && $past(!pwr_en, 2)) |-> !need_clk);
endmodule

// File: tb/test_usb_clkgate_ctrl.sv
module test_usb_clkgate_ctrl;
    localparam int IDLE_T = 3;
    localparam int HOLD_T = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b1;
    logic tick_1ms = 1'b0;
    logic bus_act = 1'b0;
    logic dma_acc = 1'b0;
    logic ctl_we = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic [1:0] stat_rdata;
    logic dev_clk_en, mst_clk_en, slv_clk_en, suspended, need_clk;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    usb_clkgate_ctrl #(.IDLE_TICKS(IDLE_T), .HOLD_TICKS(HOLD_T)) i_usb_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tick_1ms(tick_1ms),
        .bus_act(bus_act), .dma_acc(dma_acc), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_rdata(stat_rdata), .dev_clk_en(dev_clk_en), .mst_clk_en(mst_clk_en),
        .slv_clk_en(slv_clk_en), .suspended(suspended), .need_clk(need_clk)
    );

    // Behavioural reference model
    int  m_idle, m_hold_cnt;
    bit  m_susp, m_hold, m_req, m_force;
    bit  m_s1_dev, m_s1_mst, m_s2_dev, m_s2_mst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle = 0; m_hold_cnt = 0; m_susp = 0; m_hold = 0;
            m_req = 0; m_force = 0;
            m_s1_dev = 0; m_s1_mst = 0; m_s2_dev = 0; m_s2_mst = 0;
        end else begin
            bit en_d, en_m;
            en_d = pwr_en && (!m_susp || m_req);
            en_m = pwr_en && (m_hold || m_force);
            m_s2_dev = m_s1_dev; m_s2_mst = m_s1_mst;
            m_s1_dev = en_d;     m_s1_mst = en_m;
            if (!m_susp) begin
                if (bus_act) m_idle = 0;
                else if (tick_1ms) begin
                    m_idle++;
                    if (m_idle == IDLE_T) begin m_susp = 1; m_idle = 0; end
                end
            end else if (bus_act) m_susp = 0;
            if (!m_hold) begin
                if (dma_acc) begin m_hold = 1; m_hold_cnt = 0; end
            end else if (dma_acc) m_hold_cnt = 0;
            else if (tick_1ms) begin
                m_hold_cnt++;
                if (m_hold_cnt == HOLD_T) begin m_hold = 0; m_hold_cnt = 0; end
            end
            if (ctl_we) begin m_req = ctl_wdata[0]; m_force = ctl_wdata[1]; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_dev, e_mst;
            e_dev = pwr_en && (!m_susp || m_req);
            e_mst = pwr_en && (m_hold || m_force);
            chk("R1/R2", "suspended", suspended, m_susp);
            chk("R3", "dev_clk_en", dev_clk_en, e_dev);
            chk("R5/R6", "mst_clk_en", mst_clk_en, e_mst);
            chk("R7", "slv_clk_en", slv_clk_en, pwr_en);
            chk("R4", "stat_rdata", stat_rdata, {m_s2_mst, m_s2_dev});
            chk("R8", "need_clk", need_clk, m_s2_mst | m_s2_dev);
        end
    end

    task automatic cyc(input bit t, input bit a, input bit d);
        tick_1ms = t; bus_act = a; dma_acc = d;
        @(negedge clk);
        tick_1ms = 0; bus_act = 0; dma_acc = 0;
    endtask

    task automatic wr(input logic [1:0] v);
        ctl_we = 1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "suspended in reset", suspended, 0);
        chk("R9", "stat in reset", stat_rdata, 0);
        chk("R9", "need in reset", need_clk, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R9", "suspended after reset", suspended, 0);
        // R1: idle into suspend
        ticks(IDLE_T - 1);
        chk("R1", "not yet suspended", suspended, 0);
        cyc(1, 0, 0);
        chk("R1", "suspended after last tick", suspended, 1);
        repeat (3) cyc(0, 0, 0);
        // R2: wake on activity
        cyc(0, 1, 0);
        chk("R2", "woke", suspended, 0);
        // R2: activity coinciding with tick
        ticks(IDLE_T - 1);
        cyc(1, 1, 0);
        ticks(IDLE_T - 1);
        chk("R2", "tick with activity not counted", suspended, 0);
        ticks(1);
        chk("R2", "suspend after full window", suspended, 1);
        // R3: software request in suspend
        wr(2'b01);
        repeat (3) cyc(0, 0, 0);
        chk("R3", "request keeps dev clock", dev_clk_en, 1);
        chk("R3", "status on", stat_rdata[0], 1);
        wr(2'b00);
        repeat (3) cyc(0, 0, 0);
        chk("R3", "cleared request drops", dev_clk_en, 0);
        cyc(0, 1, 0);
        // R5: DMA hold and restart
        cyc(0, 0, 1);
        chk("R5", "master on", mst_clk_en, 1);
        ticks(HOLD_T - 1);
        cyc(1, 0, 1);
        ticks(HOLD_T - 1);
        chk("R5", "restart keeps master", mst_clk_en, 1);
        ticks(1);
        chk("R5", "master off after window", mst_clk_en, 0);
        // R6: force
        wr(2'b10);
        ticks(HOLD_T + 2);
        chk("R6", "forced master", mst_clk_en, 1);
        wr(2'b00);
        repeat (3) cyc(0, 0, 0);
        // R7: power off mid-hold
        cyc(0, 0, 1);
        wr(2'b11);
        pwr_en = 0;
        repeat (4) cyc(0, 0, 0);
        chk("R7", "all enables off", {dev_clk_en, mst_clk_en, slv_clk_en}, 0);
        chk("R8", "need off", need_clk, 0);
        pwr_en = 1;
        repeat (4) cyc(0, 0, 0);
        chk("R8", "need back on", need_clk, 1);
        ticks(IDLE_T + 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule